// File: doc/BRIEF.md
# Coprocessor Error Interrupt Controller

This block turns the processor's floating-point error indication into two outputs. One is a level interrupt request for the system interrupt controller, raised on the coprocessor error line (IRQ13). The other is an active-low ignore-error output back to the processor. The error input is active low and asynchronous, so it passes through a flop synchronizer before any logic uses it. A configuration enable bit gates all of the behaviour. While that bit is clear, the error input counts as inactive.

Software acknowledges an error by writing to the coprocessor error I/O port. The register decode lies outside this block and delivers that write as a one-cycle strobe. A strobe that arrives while the synchronized error is active arms the ignore-error output, and the output then asserts. No software action releases it. It drops only when the error input goes inactive or the enable bit is cleared. The synchronized error also gates the output directly, so the output can never be asserted while no error is present.

Top module: `cpx_err_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves `irq_req` at 0 and `ignore_n_out` at 1, clears the armed state and resets the synchronizer to the inactive (high) level.
- R2: With `cfg_enable` at 1, `irq_req` reads 1 after the second rising clock edge that follows `err_n_in` falling to 0 (two-flop synchronizer), and not after the first.
- R3: With `cfg_enable` at 1, `irq_req` is a level that follows the synchronized error and returns to 0 after the second rising edge that follows `err_n_in` rising to 1.
- R4: While `cfg_enable` is 0, `irq_req` stays 0 and `ignore_n_out` stays 1 whatever `err_n_in` and `port_wr` do.
- R5: A `port_wr` pulse sampled on a rising edge while the synchronized error is active and enabled drives `ignore_n_out` to 0 right after that edge.
- R6: A `port_wr` pulse sampled while the synchronized error is inactive has no effect: `ignore_n_out` stays 1, including after the error later becomes active, until a new write arrives.
- R7: Once `ignore_n_out` is 0 it stays 0, with or without further writes, until the synchronized error goes inactive. It then returns to 1 in the same cycle that `irq_req` drops.
- R8: `ignore_n_out` is never 0 while the synchronized, enabled error is inactive.
- R9: Clearing `cfg_enable` negates `irq_req` and `ignore_n_out` combinationally, without waiting for a clock edge. The armed state is cleared at the next edge, so setting the enable bit again does not reassert `ignore_n_out` without a new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | Configuration enable for the coprocessor error function |
| err_n_in | input | 1 | Asynchronous floating-point error from the processor, active low |
| port_wr | input | 1 | One-cycle strobe for a write to the coprocessor error port |
| ignore_n_out | output | 1 | Ignore-error output to the processor, active low |
| irq_req | output | 1 | Level interrupt request toward the interrupt controller |

## Verification
The hardest case to reach from the ports is an armed ignore-error state that survives a change on the enable bit. It is hard because the armed state cannot be seen while the enable bit is clear. The stimulus arms the output first. It then holds the enable bit clear across several edges, sending a write meanwhile, and sets the bit again while the error is still held active. An output that reasserts at that point would show a stale latch. A second case is a write that arrives while the error is still travelling through the synchronizer. It has to be ignored even though the raw input is already active.

// File: rtl/cpx_err_pkg.sv
package cpx_err_pkg;

    localparam int unsigned SYNC_STAGES_DEF = 2;

    typedef struct packed {
        logic irq;
        logic ignore;
    } cpx_out_t;

    // active when enabled and the synchronized (active-low) error is low
    function automatic logic err_gate(input logic en, input logic err_n_sync);
        return en & ~err_n_sync;
    endfunction

endpackage

// File: rtl/cpx_err_sync.sv
module cpx_err_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_n,
    output logic q_n
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= d_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_n = chain[STAGES-1];

    // R1: the output reads inactive on the edge after reset
    a_r1_sync_idle: assert property (@(posedge clk) rst |=> q_n);
endmodule

// File: rtl/cpx_err_ignore_latch.sv
module cpx_err_ignore_latch (
    input  logic clk,
    input  logic rst,
    input  logic err_act,
    input  logic wr_strobe,
    output logic armed
);
    always_ff @(posedge clk) begin
        if (rst)                       armed <= 1'b0;
        else if (!err_act)             armed <= 1'b0;
        else if (wr_strobe)            armed <= 1'b1;
    end

    // R5: a write while the error is active arms the latch
    a_r5_arm: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe && err_act) |=> armed);
    // R7: the armed state holds while the error stays active
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (armed && err_act) |=> armed);
    // R6: an inactive error leaves nothing armed
    a_r6_no_arm_idle: assert property (@(posedge clk) disable iff (rst)
        (!err_act) |=> !armed);
endmodule

// File: rtl/cpx_err_gate.sv
module cpx_err_gate
    import cpx_err_pkg::*;
(
    input  logic     en,
    input  logic     err_n_sync,
    input  logic     armed,
    output logic     err_act,
    output cpx_out_t outs
);
    always_comb begin
        err_act     = err_gate(en, err_n_sync);
        outs.irq    = err_act;
        outs.ignore = armed & err_act;
    end
endmodule

// File: rtl/cpx_err_ctrl.sv
module cpx_err_ctrl
    import cpx_err_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_enable,
    input  logic err_n_in,
    input  logic port_wr,
    output logic ignore_n_out,
    output logic irq_req
);
    logic     err_n_sync;
    logic     err_act;
    logic     armed;
    cpx_out_t outs;

    cpx_err_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_n (err_n_in),
        .q_n (err_n_sync)
    );

    cpx_err_ignore_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .err_act   (err_act),
        .wr_strobe (port_wr),
        .armed     (armed)
    );

    cpx_err_gate u_gate (
        .en         (cfg_enable),
        .err_n_sync (err_n_sync),
        .armed      (armed),
        .err_act    (err_act),
        .outs       (outs)
    );

    assign irq_req      = outs.irq;
    assign ignore_n_out = ~outs.ignore;

    // R8: ignore-error is gated by the synchronized enabled error
    a_r8_ign_gated: assert property (@(posedge clk) disable iff (rst)
        (!ignore_n_out) |-> (cfg_enable && !err_n_sync));
    // R4: disabled means both outputs idle
    a_r4_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        (!cfg_enable) |-> (!irq_req && ignore_n_out));
    // R9: the edge after a disabled cycle leaves the latch clear
    a_r9_disarm: assert property (@(posedge clk) disable iff (rst)
        (!cfg_enable) |=> !armed);
    // R1: outputs idle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!irq_req && ignore_n_out));
endmodule

// File: tb/cpx_err_ctrl_bench.sv
module cpx_err_ctrl_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_enable = 1'b0;
    logic err_n_in = 1'b1;
    logic port_wr = 1'b0;
    logic ignore_n_out;
    logic irq_req;

    always #5 clk = ~clk;

    cpx_err_ctrl u_cpx_err_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cfg_enable   (cfg_enable),
        .err_n_in     (err_n_in),
        .port_wr      (port_wr),
        .ignore_n_out (ignore_n_out),
        .irq_req      (irq_req)
    );

    typedef struct {
        logic  irq;
        logic  ign_n;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    task automatic check(input logic a_irq, input logic a_ign,
                         input logic e_irq, input logic e_ign, input string tag);
        n_checks++;
        if (a_irq !== e_irq || a_ign !== e_ign) begin
            n_fail++;
            $display("FAIL %s: irq_req=%b ignore_n_out=%b expected irq_req=%b ignore_n_out=%b",
                     tag, a_irq, a_ign, e_irq, e_ign);
        end
    endtask

    // driver: one cycle per call, expectation is for after the coming edge
    task automatic step(input logic r, input logic en, input logic en_n,
                        input logic wr, input logic e_irq, input logic e_ign,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; cfg_enable = en; err_n_in = en_n; port_wr = wr;
        e.irq = e_irq; e.ign_n = e_ign; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compares after each rising edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(irq_req, ignore_n_out, e.irq, e.ign_n, e.tag);
        end
    end

    initial begin
        // reset with error already active at the pin
        step(1, 1, 0, 0, 0, 1, "R1 in reset");
        step(1, 1, 0, 0, 0, 1, "R1 in reset");
        step(0, 1, 1, 0, 0, 1, "R1 after reset");
        // R2: two-edge latency; write during first edge is ignored (R6)
        step(0, 1, 0, 1, 0, 1, "R6 write before sync");
        step(0, 1, 0, 0, 1, 1, "R2 irq after second edge");
        step(0, 1, 0, 0, 1, 1, "R3 irq level");
        // R5 arm, R7 hold
        step(0, 1, 0, 1, 1, 0, "R5 armed by write");
        step(0, 1, 0, 0, 1, 0, "R7 hold");
        step(0, 1, 0, 1, 1, 0, "R7 second write");
        step(0, 1, 1, 0, 1, 0, "R7 hold one edge after release");
        step(0, 1, 1, 0, 0, 1, "R3 R7 release together");
        // R6: write while error inactive, then error comes
        step(0, 1, 1, 1, 0, 1, "R6 idle write");
        step(0, 1, 0, 0, 0, 1, "R6 no arm");
        step(0, 1, 0, 0, 1, 1, "R6 irq without ignore");
        step(0, 1, 0, 0, 1, 1, "R6 still not armed");
        step(0, 1, 0, 1, 1, 0, "R5 armed again");
        // R9 combinational disable
        @(negedge clk);
        cfg_enable = 1'b0;
        #1;
        check(irq_req, ignore_n_out, 0, 1, "R9 immediate disable");
        step(0, 0, 0, 0, 0, 1, "R4 disabled");
        step(0, 0, 0, 1, 0, 1, "R4 write while disabled");
        step(0, 0, 1, 0, 0, 1, "R4 disabled error toggle");
        step(0, 0, 0, 0, 0, 1, "R4 disabled");
        step(0, 0, 0, 0, 0, 1, "R4 disabled");
        step(0, 1, 0, 0, 1, 1, "R9 re-enable not re-armed");
        step(0, 1, 0, 0, 1, 1, "R9 stays unarmed");
        step(0, 1, 0, 1, 1, 0, "R5 arm before reset");
        // R1 reset mid-operation
        step(1, 1, 0, 0, 0, 1, "R1 reset clears");
        step(0, 1, 0, 0, 0, 1, "R1 sync restarts");
        step(0, 1, 0, 0, 1, 1, "R1 R2 no stale arm");
        step(0, 1, 1, 0, 1, 1, "R3 hold one edge");
        step(0, 1, 1, 0, 0, 1, "R3 falls");
        @(negedge clk);
        @(negedge clk);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 2000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule